// File: doc/BRIEF.md
# PCI Target Posted Write Buffer

This block is the write half of a PCI target. It watches address phases from another bus initiator and claims memory write cycles whose address falls in its decode window. Each data beat is posted into an on-chip buffer together with its address and byte enables. The bus is released as soon as the final beat is accepted, and the buffer drains in arrival order to a simple valid/ready memory write port in the background.

The buffer holds 48 doublewords. It is sized as a 16-slot bus-side part plus a 32-slot memory-side part, and implemented as one RAM. When it is full, the target inserts wait states. A new cycle that arrives while the buffer is full is retried. A registered empty flag tells a companion read path when every posted write has reached memory, so that read-after-write ordering can be enforced outside this block.

Top module: `pci_post_wbuf`

## Requirements
- R1: An address phase (first clock with `frame_n` low after it was high) whose `cbe_n` equals 4'b0111 (memory write) and whose `ad[31:WIN_BITS]` equals `MEM_BASE[31:WIN_BITS]` is claimed: `devsel_n` is low from the next clock.
- R2: When a claimed cycle finds buffer space, `trdy_n` goes low in the same clock as `devsel_n`.
- R3: On every rising edge with `irdy_n` and `trdy_n` both low, one beat is stored. Its fields are address, `ad` as data and `~cbe_n` as byte enables (bit i enables byte lane i). The first beat's address is the address-phase address with bits 1:0 cleared, and each later beat's address is 4 higher.
- R4: Stored beats appear on the memory port in acceptance order. While `mem_wr_valid` is high and `mem_wr_ready` is low, address, data and byte enables hold steady.
- R5: An address phase with an address outside the window, or with any command other than 4'b0111, is ignored: `devsel_n` stays high and nothing is written to memory.
- R6: With the memory port stalled, exactly 48 beats are accepted without wait states. After that `trdy_n` stays high until an entry drains.
- R7: A claimable cycle that arrives while the buffer is full is retried. `devsel_n` and `stop_n` go low with `trdy_n` high, both are released the clock after the final data phase (`frame_n` high, `irdy_n` low), and nothing is stored.
- R8: The beat accepted with `frame_n` high ends the transaction. `devsel_n` and `trdy_n` are high from the next clock, even while posted data is still waiting for memory.
- R9: `wbuf_empty` is high exactly when no posted beat awaits a memory handshake. It is low from the clock after the first beat is accepted.
- R10: After synchronous reset, `devsel_n`, `trdy_n` and `stop_n` are high, `mem_wr_valid` is low and `wbuf_empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Cycle framing from initiator, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cbe_n | input | 4 | Command in address phase, byte enables (active low) in data phases |
| ad | input | 32 | Address in address phase, write data in data phases |
| devsel_n | output | 1 | Target claims the cycle, active low |
| trdy_n | output | 1 | Target ready to take data, active low |
| stop_n | output | 1 | Target requests retry, active low |
| mem_wr_valid | output | 1 | A posted write is offered to memory |
| mem_wr_ready | input | 1 | Memory takes the offered write |
| mem_wr_addr | output | 32 | Doubleword-aligned memory address |
| mem_wr_data | output | 32 | Write data |
| mem_wr_be | output | 4 | Byte enables, active high |
| wbuf_empty | output | 1 | No posted write is outstanding |

## Verification
The bus side can accept a beat on the same edge as the memory side retires one. When the buffer is at or near 48 entries, that coincidence decides whether `trdy_n` stays low or a wait state is inserted. The case is provoked by a 120-beat burst while memory readiness alternates every clock, so the occupancy climbs to the limit and then sits at it with pushes and pops landing together. It is judged by a scoreboard that must see every beat exactly once and in order, by the wait states that must appear, and by a property that occupancy never exceeds 48.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
  } wentry_t;
endpackage

// File: rtl/pwb_post_fifo.sv
module pwb_post_fifo
  import pwb_pkg::*;
#(
  parameter int BUS_SLOTS = 16,
  parameter int MEM_SLOTS = 32,
  localparam int DEPTH = BUS_SLOTS + MEM_SLOTS,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  wentry_t       push_entry,
  output logic          space_next,
  output logic [CW-1:0] occ,
  output logic          out_valid,
  output wentry_t       out_entry,
  input  logic          out_ready,
  output logic          empty
);
  wentry_t       ram [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] occ_nxt, ram_used;
  logic          pop, load;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pop        = out_valid && out_ready;
  assign ram_used   = occ - CW'(out_valid);
  assign load       = (ram_used != '0) && (!out_valid || out_ready);
  assign occ_nxt    = occ + CW'(push) - CW'(pop);
  assign space_next = occ_nxt < CW'(DEPTH);

  // RAM write port and registered read, free of reset for block RAM use
  always_ff @(posedge clk) begin
    if (push) ram[wr_ptr] <= push_entry;
    if (load) out_entry <= ram[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      occ       <= '0;
      out_valid <= 1'b0;
      empty     <= 1'b1;
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (load) rd_ptr <= ptr_inc(rd_ptr);
      occ   <= occ_nxt;
      empty <= (occ_nxt == '0);
      if (load)     out_valid <= 1'b1;
      else if (pop) out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pwb_bus_fsm.sv
module pwb_bus_fsm
  import pwb_pkg::*;
#(
  parameter int          WIN_BITS = 20,
  parameter logic [31:0] MEM_BASE = 32'h0010_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic [3:0]  cbe_n,
  input  logic [31:0] ad,
  input  logic        space_next,
  output logic        devsel_n,
  output logic        trdy_n,
  output logic        stop_n,
  output logic        push,
  output wentry_t     push_entry
);
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_RETRY} bus_st_t;

  bus_st_t     st;
  logic        frame_q;
  logic [31:0] cur_addr;
  logic        start, hit;

  assign start = (st == ST_IDLE) && frame_q && !frame_n;
  assign hit   = (cbe_n == CMD_MEM_WR) && (ad[31:WIN_BITS] == MEM_BASE[31:WIN_BITS]);
  assign push  = (st == ST_XFER) && !irdy_n && !trdy_n;
  assign push_entry = '{addr: cur_addr, data: ad, be: ~cbe_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      frame_q  <= 1'b1;
      cur_addr <= '0;
      devsel_n <= 1'b1;
      trdy_n   <= 1'b1;
      stop_n   <= 1'b1;
    end else begin
      frame_q <= frame_n;
      case (st)
        ST_IDLE: begin
          if (start && hit) begin
            devsel_n <= 1'b0;
            cur_addr <= {ad[31:2], 2'b00};
            if (space_next) begin
              st     <= ST_XFER;
              trdy_n <= 1'b0;
            end else begin
              st     <= ST_RETRY;
              stop_n <= 1'b0;
            end
          end
        end
        ST_XFER: begin
          if (push) cur_addr <= cur_addr + 32'd4;
          if (push && frame_n) begin
            st       <= ST_IDLE;
            devsel_n <= 1'b1;
            trdy_n   <= 1'b1;
          end else begin
            trdy_n <= !space_next;
          end
        end
        ST_RETRY: begin
          if (frame_n && !irdy_n) begin
            st       <= ST_IDLE;
            devsel_n <= 1'b1;
            stop_n   <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pci_post_wbuf.sv
module pci_post_wbuf
  import pwb_pkg::*;
#(
  parameter int          BUS_SLOTS = 16,
  parameter int          MEM_SLOTS = 32,
  parameter int          WIN_BITS  = 20,
  parameter logic [31:0] MEM_BASE  = 32'h0010_0000,
  localparam int DEPTH = BUS_SLOTS + MEM_SLOTS,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic [3:0]  cbe_n,
  input  logic [31:0] ad,
  output logic        devsel_n,
  output logic        trdy_n,
  output logic        stop_n,
  output logic        mem_wr_valid,
  input  logic        mem_wr_ready,
  output logic [31:0] mem_wr_addr,
  output logic [31:0] mem_wr_data,
  output logic [3:0]  mem_wr_be,
  output logic        wbuf_empty
);
  logic          push, space_next;
  wentry_t       push_entry, out_entry;
  logic [CW-1:0] occ;

  pwb_bus_fsm #(.WIN_BITS(WIN_BITS), .MEM_BASE(MEM_BASE)) u_bus (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .cbe_n(cbe_n),
    .ad(ad), .space_next(space_next), .devsel_n(devsel_n), .trdy_n(trdy_n),
    .stop_n(stop_n), .push(push), .push_entry(push_entry)
  );

  pwb_post_fifo #(.BUS_SLOTS(BUS_SLOTS), .MEM_SLOTS(MEM_SLOTS)) u_buf (
    .clk(clk), .rst(rst), .push(push), .push_entry(push_entry),
    .space_next(space_next), .occ(occ), .out_valid(mem_wr_valid),
    .out_entry(out_entry), .out_ready(mem_wr_ready), .empty(wbuf_empty)
  );

  assign mem_wr_addr = out_entry.addr;
  assign mem_wr_data = out_entry.data;
  assign mem_wr_be   = out_entry.be;
endmodule

// File: rtl/pwb_chk.sv
module pwb_chk #(
  parameter int DEPTH = 48,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          devsel_n,
  input logic          trdy_n,
  input logic          stop_n,
  input logic          mem_wr_valid,
  input logic          mem_wr_ready,
  input logic [31:0]   mem_wr_addr,
  input logic [31:0]   mem_wr_data,
  input logic [3:0]    mem_wr_be,
  input logic          wbuf_empty,
  input logic [CW-1:0] occ
);
  // R2
  trdy_with_devsel_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(devsel_n) && stop_n) |-> !trdy_n);
  // R3
  trdy_needs_claim_chk: assert property (@(posedge clk) disable iff (rst)
    !trdy_n |-> !devsel_n);
  // R4
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_addr)
      && $stable(mem_wr_data) && $stable(mem_wr_be)));
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(DEPTH));
  // R6
  full_waits_chk: assert property (@(posedge clk) disable iff (rst)
    (occ == CW'(DEPTH)) |-> trdy_n);
  // R7
  retry_no_data_chk: assert property (@(posedge clk) disable iff (rst)
    !stop_n |-> (trdy_n && !devsel_n));
  // R9
  empty_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
    wbuf_empty |-> !mem_wr_valid);
endmodule

bind pci_post_wbuf pwb_chk #(.DEPTH(BUS_SLOTS + MEM_SLOTS)) u_chk (
  .clk(clk), .rst(rst), .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
  .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
  .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be),
  .wbuf_empty(wbuf_empty), .occ(occ)
);

// File: tb/tb_pci_post_wbuf.sv
module tb_pci_post_wbuf;
  logic        clk = 1'b0, rst = 1'b1;
  logic        frame_n = 1'b1, irdy_n = 1'b1;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad = '0;
  logic        devsel_n, trdy_n, stop_n, mem_wr_valid, mem_wr_ready;
  logic [31:0] mem_wr_addr, mem_wr_data;
  logic [3:0]  mem_wr_be;
  logic        wbuf_empty;

  int checks = 0, fails = 0, cyc = 0;
  int ready_mode = 1;   // 0 stall, 1 always, 2 alternate
  bit finished = 0;
  logic [67:0] sb[$];

  always #2 clk = ~clk;

  pci_post_wbuf dut (.*);

  task automatic chk(input bit ok, input string req, input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: drives ready and scores memory writes (R4)
  always @(negedge clk) begin
    cyc++;
    mem_wr_ready = (ready_mode == 1) || (ready_mode == 2 && cyc[0]);
    if (!rst && mem_wr_valid && mem_wr_ready) begin
      if (sb.size() == 0) chk(0, "R4 unexpected write", {mem_wr_addr, mem_wr_data, mem_wr_be}, '0);
      else begin
        logic [67:0] e;
        e = sb.pop_front();
        chk({mem_wr_addr, mem_wr_data, mem_wr_be} == e, "R3/R4 order and content",
            {mem_wr_addr, mem_wr_data, mem_wr_be}, e);
      end
    end
  end

  function automatic logic [3:0] be_of(input int i);
    return (i % 5 == 0) ? 4'hF : 4'(1 << (i % 4)) | 4'(i % 3);
  endfunction

  // driver: burst write, returns beat index of first wait (-1 if none)
  task automatic do_write(input logic [31:0] a, input int n, input logic [31:0] seed, output int first_wait);
    first_wait = -1;
    @(negedge clk);
    frame_n = 0; irdy_n = 1; ad = a; cbe_n = 4'b0111;
    @(negedge clk);
    chk(!devsel_n, "R1 devsel after claim", 68'(devsel_n), 68'(0));
    chk(!trdy_n, "R2 trdy with devsel", 68'(trdy_n), 68'(0));
    for (int i = 0; i < n; i++) begin
      ad = seed + 32'(i) * 32'h0101_0101; cbe_n = ~be_of(i); irdy_n = 0; frame_n = (i == n - 1);
      while (trdy_n) begin
        if (first_wait < 0) first_wait = i;
        @(negedge clk);
      end
      sb.push_back({(a & ~32'd3) + 32'(4 * i), ad, be_of(i)});
      @(negedge clk);
    end
    frame_n = 1; irdy_n = 1; cbe_n = 4'hF;
    chk(devsel_n && trdy_n, "R8 released after last beat", {devsel_n, trdy_n}, 68'b11);
  endtask

  task automatic ignored(input logic [31:0] a, input logic [3:0] cmd);
    @(negedge clk);
    frame_n = 0; ad = a; cbe_n = cmd;
    @(negedge clk);
    frame_n = 1; irdy_n = 0; cbe_n = 4'h0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(devsel_n && !mem_wr_valid && wbuf_empty, "R5 cycle ignored",
          {devsel_n, mem_wr_valid, wbuf_empty}, 68'b101);
    end
    irdy_n = 1;
  endtask

  task automatic drain(input string req);
    int k = 0;
    while (!wbuf_empty && k < 2000) begin @(negedge clk); k++; end
    @(negedge clk);
    chk(wbuf_empty && sb.size() == 0 && !mem_wr_valid, req, {wbuf_empty, 32'(sb.size())}, {1'b1, 32'd0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int fw;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10
    chk(devsel_n && trdy_n && stop_n && !mem_wr_valid && wbuf_empty, "R10 reset state",
        {devsel_n, trdy_n, stop_n, mem_wr_valid, wbuf_empty}, 68'b11101);

    // R9: single write, memory stalled, flag low then high after drain
    ready_mode = 0;
    do_write(32'h0010_0013, 1, 32'hA5A5_0000, fw);
    chk(!wbuf_empty, "R9 empty low after post", 68'(wbuf_empty), 68'(0));
    chk(devsel_n, "R8 bus free while data posted", 68'(devsel_n), 68'(1));
    ready_mode = 1;
    drain("R9 empty after drain");

    // R3: burst with increments and varied byte enables
    do_write(32'h0010_4000, 8, 32'h1000_0000, fw);
    chk(fw == -1, "R3 burst without waits", 68'(fw), 68'(-1));
    drain("R4 burst drained in order");

    // R5: out of range and wrong command
    ignored(32'h0030_0000, 4'b0111);
    ignored(32'h0010_0000, 4'b0110);

    // R6: capacity with stalled memory
    ready_mode = 0;
    fork
      begin repeat (140) @(negedge clk); ready_mode = 1; end
      do_write(32'h0018_0000, 60, 32'h2000_0000, fw);
    join
    chk(fw == 48, "R6 first wait after 48 beats", 68'(fw), 68'(48));
    drain("R6 all drained");

    // R7: retry while full
    ready_mode = 0;
    do_write(32'h0011_0000, 48, 32'h3000_0000, fw);
    chk(fw == -1, "R6 48 beats no wait", 68'(fw), 68'(-1));
    @(negedge clk);
    frame_n = 0; ad = 32'h0012_0000; cbe_n = 4'b0111;
    @(negedge clk);
    chk(!stop_n && !devsel_n && trdy_n, "R7 retry signalled",
        {stop_n, devsel_n, trdy_n}, 68'b001);
    frame_n = 1; irdy_n = 0; ad = 32'hDEAD_BEEF; cbe_n = 4'h0;
    @(negedge clk);
    irdy_n = 1; cbe_n = 4'hF;
    chk(stop_n && devsel_n, "R7 retry released", {stop_n, devsel_n}, 68'b11);
    ready_mode = 1;
    drain("R7 nothing stored by retried cycle");

    // push and pop on the same edge near full
    ready_mode = 2;
    do_write(32'h0015_0000, 120, 32'h4000_0000, fw);
    chk(fw > 0, "R6 waits under alternating drain", 68'(fw), 68'(1));
    ready_mode = 1;
    drain("R4 concurrent accept and drain");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule